// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block moves stereo PCM samples between the system clock domain and a three-wire serial audio link. The link has a bit clock, a word clock that marks the channel, and one data line in each direction. The block runs entirely on the system clock. It oversamples the bit clock and word clock through two-flop synchronizers and acts on the detected edges. It assembles each received left/right pair into two 24-bit sample registers and raises a one-cycle pulse when a pair is complete. In parallel it shifts a left/right pair supplied by the core onto the output line.

A static configuration sets three things: the justification (I2S, left-justified or right-justified), the frame length (32 or 64 bit clocks), and the word width (16, 18, 20 or 24 bits). One slot-mapping function serves both directions. It turns the bit position since the last word-clock edge into a channel, a bit index and a hit flag. In right-justified mode the word is placed back from the end of the half-frame. The configuration is expected to change only while reset is asserted.

Samples on both sides are carried left-aligned. Bit 23 holds the word MSB, and the bits below the configured word width are zero on receive and are not sent on transmit.

Top module: `aud_serial_port`

## Requirements
- R1: With `cfg_fmt`=2'b01 (left-justified, also used for the unused code 2'b11), the word MSB is in the first bit period after a word-clock transition, and the following bits come out MSB first.
- R2: With `cfg_fmt`=2'b00 (I2S), the MSB is in the second bit period after the transition. With a 16-bit word in a 16-period half, the LSB therefore falls in the first period of the next half.
- R3: With `cfg_fmt`=2'b10 (right-justified), the LSB is in the last bit period of the half. The word starts at period half_length minus word_width, counted from 0.
- R4: For I2S, word clock low marks the left channel. For the other formats, word clock high marks the left channel. The left word of a frame precedes its right word, and the received pair reports each word on its own channel port.
- R5: `cfg_frame64`=1 gives 32 bit periods per channel. `cfg_frame64`=0 gives 16 bit periods per channel, and the word width is then 16 bits whatever `cfg_width` holds.
- R6: `cfg_width` 2'b00/01/10/11 selects 16/18/20/24 bits. A received word appears in bits 23 down to 24 minus width of `rx_left`/`rx_right`, the lower bits are zero, and input bits outside the word have no effect.
- R7: `sd_out` is 0 in every bit period outside the word. It changes only in the system cycle that follows a detected bit-clock falling edge.
- R8: `rx_valid` is a one-cycle pulse that is raised after the last bit of a right word, provided a left word has completed since reset. `rx_left` and `rx_right` change only together with that pulse.
- R9: The transmit pair is sampled at the bit-clock falling edge where the word clock enters the left level. `tx_right` is held from that edge, so changes on the inputs later in the frame do not alter the words being sent.
- R10: After reset, `rx_valid`, `rx_left`, `rx_right` and `sd_out` are 0, and `sd_out` stays 0 until the first word-clock transition is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Justification select (00 I2S, 01 left, 10 right) |
| cfg_frame64 | input | 1 | 1: 64-period frame, 0: 32-period frame |
| cfg_width | input | 2 | Word width select (16/18/20/24) |
| bck_in | input | 1 | Serial bit clock, asynchronous |
| lr_in | input | 1 | Word clock, asynchronous |
| sd_in | input | 1 | Serial data input |
| tx_left | input | 24 | Left sample to send, left-aligned |
| tx_right | input | 24 | Right sample to send, left-aligned |
| sd_out | output | 1 | Serial data output |
| rx_left | output | 24 | Last received left sample, left-aligned |
| rx_right | output | 24 | Last received right sample, left-aligned |
| rx_valid | output | 1 | One-cycle pulse per completed received pair |

## Verification
Every result is due a fixed number of system cycles after the bit-clock edge that causes it: two synchronizer stages plus one output register. This puts `sd_out` three cycles after a falling edge, and `rx_valid` with the sample ports three cycles after the rising edge that carries the final right bit. The bench holds each bit-clock phase for six system cycles. It reads `sd_out` just before the next rising edge and captures the received pair on the falling edge of the system clock while the pulse is high. It then compares the captured words at the end of each configuration, so no check depends on the exact order of processes at a clock edge.

// File: rtl/aud_sp_pkg.sv
package aud_sp_pkg;

    localparam int SMP_W  = 24;
    localparam int POS_W  = 6;
    localparam int IDX_W  = 5;
    localparam int SYNC_N = 2;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_RSV = 2'b11
    } fmt_e;

    typedef struct packed {
        logic             hit;
        logic             left;
        logic [IDX_W-1:0] idx;
    } slot_t;

    // effective word length in bits
    function automatic int word_len(input logic [1:0] wsel, input logic f64);
        if (!f64) return 16;
        case (wsel)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

    // bits of a left-aligned sample that lie below the word
    function automatic logic [SMP_W-1:0] tail_mask(input logic [1:0] wsel, input logic f64);
        int w;
        w = word_len(wsel, f64);
        return (SMP_W'(1) << (SMP_W - w)) - SMP_W'(1);
    endfunction

    function automatic logic left_level(input fmt_e fmt, input logic lr);
        return (fmt == FMT_I2S) ? !lr : lr;
    endfunction

    // map a bit position inside the current half onto channel and word index
    function automatic slot_t map_slot(input fmt_e fmt, input logic f64,
                                       input logic [1:0] wsel,
                                       input logic [POS_W-1:0] pos, input logic lr);
        slot_t s;
        int half, w, p, e, off, d;
        logic lft;
        half = f64 ? 32 : 16;
        w    = word_len(wsel, f64);
        p    = int'(pos);
        lft  = left_level(fmt, lr);
        if (fmt == FMT_I2S) begin
            if (p == 0) begin
                e   = half - 1;
                lft = !lft;
            end else begin
                e = p - 1;
            end
        end else begin
            e = p;
        end
        off    = (fmt == FMT_RJ) ? (half - w) : 0;
        d      = e - off;
        s.hit  = (p < half) && (d >= 0) && (d < w);
        s.left = lft;
        s.idx  = s.hit ? IDX_W'(d) : '0;
        return s;
    endfunction

endpackage

// File: rtl/aud_edge_sync.sv
module aud_edge_sync
    import aud_sp_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic bck,
    input  logic lr,
    input  logic sd,
    output logic bck_rise,
    output logic bck_fall,
    output logic lr_s,
    output logic sd_s
);
    localparam int LINES = 3;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] chain [STAGES];
    logic             bck_d;

    assign raw = {sd, lr, bck};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= (g == 0) ? raw : chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) bck_d <= 1'b0;
        else     bck_d <= chain[STAGES-1][0];
    end

    assign bck_rise = chain[STAGES-1][0] & ~bck_d;
    assign bck_fall = ~chain[STAGES-1][0] & bck_d;
    assign lr_s     = chain[STAGES-1][1];
    assign sd_s     = chain[STAGES-1][2];
endmodule

// File: rtl/aud_slot_track.sv
module aud_slot_track
    import aud_sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ev,
    input  logic             lr,
    output logic [POS_W-1:0] pos_now,
    output logic             chg,
    output logic             locked
);
    logic             seen;
    logic             lr_last;
    logic [POS_W-1:0] pos_q;

    assign chg     = seen && (lr != lr_last);
    assign pos_now = chg ? '0 : ((&pos_q) ? pos_q : pos_q + POS_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen    <= 1'b0;
            lr_last <= 1'b0;
            pos_q   <= '0;
            locked  <= 1'b0;
        end else if (ev) begin
            seen    <= 1'b1;
            lr_last <= lr;
            pos_q   <= pos_now;
            if (chg) locked <= 1'b1;
        end
    end
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
    import aud_sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fmt_e             fmt,
    input  logic             f64,
    input  logic [1:0]       wsel,
    input  logic             rise,
    input  logic             lr,
    input  logic             sd,
    input  logic [POS_W-1:0] pos,
    input  logic             chg,
    input  logic             locked,
    output logic [SMP_W-1:0] rx_left,
    output logic [SMP_W-1:0] rx_right,
    output logic             rx_valid
);
    slot_t            m;
    logic             act;
    logic             last;
    logic             left_done;
    logic [SMP_W-1:0] acc_l, acc_r, nxt_l, nxt_r, base;

    always_comb begin
        m     = map_slot(fmt, f64, wsel, pos, lr);
        act   = rise && (locked || chg) && m.hit;
        last  = (int'(m.idx) == word_len(wsel, f64) - 1);
        nxt_l = acc_l;
        nxt_r = acc_r;
        base  = m.left ? acc_l : acc_r;
        if (m.idx == '0) base = '0;
        base[IDX_W'(SMP_W-1) - m.idx] = sd;
        if (act) begin
            if (m.left) nxt_l = base;
            else        nxt_r = base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_l     <= '0;
            acc_r     <= '0;
            left_done <= 1'b0;
            rx_left   <= '0;
            rx_right  <= '0;
            rx_valid  <= 1'b0;
        end else begin
            acc_l    <= nxt_l;
            acc_r    <= nxt_r;
            rx_valid <= 1'b0;
            if (act && last) begin
                if (m.left) begin
                    left_done <= 1'b1;
                end else if (left_done) begin
                    rx_left  <= nxt_l;
                    rx_right <= nxt_r;
                    rx_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aud_tx_ser.sv
module aud_tx_ser
    import aud_sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fmt_e             fmt,
    input  logic             f64,
    input  logic [1:0]       wsel,
    input  logic             fall,
    input  logic             lr,
    input  logic [POS_W-1:0] pos,
    input  logic             chg,
    input  logic             locked,
    input  logic [SMP_W-1:0] tx_left,
    input  logic [SMP_W-1:0] tx_right,
    output logic             sd_out
);
    slot_t            m;
    logic             live;
    logic             load;
    logic             rstart;
    logic             nbit;
    logic [SMP_W-1:0] act_l, act_r, hold_r, src_l, src_r;

    always_comb begin
        m      = map_slot(fmt, f64, wsel, pos, lr);
        live   = locked || chg;
        load   = fall && chg && left_level(fmt, lr);
        rstart = fall && live && m.hit && !m.left && (m.idx == '0);
        src_l  = load ? tx_left : act_l;
        src_r  = rstart ? hold_r : act_r;
        nbit   = 1'b0;
        if (live && m.hit)
            nbit = m.left ? src_l[IDX_W'(SMP_W-1) - m.idx]
                          : src_r[IDX_W'(SMP_W-1) - m.idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_l  <= '0;
            act_r  <= '0;
            hold_r <= '0;
            sd_out <= 1'b0;
        end else if (fall) begin
            sd_out <= nbit;
            if (load) begin
                act_l  <= tx_left;
                hold_r <= tx_right;
            end
            if (rstart) act_r <= hold_r;
        end
    end
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
    import aud_sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_fmt,
    input  logic             cfg_frame64,
    input  logic [1:0]       cfg_width,
    input  logic             bck_in,
    input  logic             lr_in,
    input  logic             sd_in,
    input  logic [SMP_W-1:0] tx_left,
    input  logic [SMP_W-1:0] tx_right,
    output logic             sd_out,
    output logic [SMP_W-1:0] rx_left,
    output logic [SMP_W-1:0] rx_right,
    output logic             rx_valid
);
    fmt_e             fmt;
    logic             bck_rise, bck_fall, lr_s, sd_s;
    logic [POS_W-1:0] rx_pos, tx_pos;
    logic             rx_chg, tx_chg, rx_locked, tx_locked;

    assign fmt = fmt_e'(cfg_fmt);

    aud_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .bck(bck_in), .lr(lr_in), .sd(sd_in),
        .bck_rise(bck_rise), .bck_fall(bck_fall), .lr_s(lr_s), .sd_s(sd_s)
    );

    aud_slot_track u_rx_trk (
        .clk(clk), .rst(rst), .ev(bck_rise), .lr(lr_s),
        .pos_now(rx_pos), .chg(rx_chg), .locked(rx_locked)
    );

    aud_slot_track u_tx_trk (
        .clk(clk), .rst(rst), .ev(bck_fall), .lr(lr_s),
        .pos_now(tx_pos), .chg(tx_chg), .locked(tx_locked)
    );

    aud_rx_deser u_rx (
        .clk(clk), .rst(rst), .fmt(fmt), .f64(cfg_frame64), .wsel(cfg_width),
        .rise(bck_rise), .lr(lr_s), .sd(sd_s), .pos(rx_pos), .chg(rx_chg),
        .locked(rx_locked), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    aud_tx_ser u_tx (
        .clk(clk), .rst(rst), .fmt(fmt), .f64(cfg_frame64), .wsel(cfg_width),
        .fall(bck_fall), .lr(lr_s), .pos(tx_pos), .chg(tx_chg), .locked(tx_locked),
        .tx_left(tx_left), .tx_right(tx_right), .sd_out(sd_out)
    );
endmodule

// File: rtl/aud_serial_port_chk.sv
module aud_serial_port_chk
    import aud_sp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bck_rise,
    input logic             bck_fall,
    input logic             tx_locked,
    input logic             sd_out,
    input logic             rx_valid,
    input logic [SMP_W-1:0] rx_left,
    input logic [SMP_W-1:0] rx_right,
    input logic [1:0]       cfg_width,
    input logic             cfg_frame64
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R8

    AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(bck_rise)); // R8

    AST_PAIR_HELD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> ($stable(rx_left) && $stable(rx_right))); // R8

    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((rx_left | rx_right) & tail_mask(cfg_width, cfg_frame64)) == '0); // R6

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_out) |-> $past(bck_fall)); // R7

    AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !tx_locked |-> !sd_out); // R10
endmodule

bind aud_serial_port aud_serial_port_chk u_chk (
    .clk(clk), .rst(rst), .bck_rise(bck_rise), .bck_fall(bck_fall),
    .tx_locked(tx_locked), .sd_out(sd_out), .rx_valid(rx_valid),
    .rx_left(rx_left), .rx_right(rx_right),
    .cfg_width(cfg_width), .cfg_frame64(cfg_frame64)
);

// File: tb/aud_serial_port_test.sv
module aud_serial_port_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_fmt;
    logic        cfg_frame64;
    logic [1:0]  cfg_width;
    logic        bck_in, lr_in, sd_in;
    logic [23:0] tx_left, tx_right;
    logic        sd_out;
    logic [23:0] rx_left, rx_right;
    logic        rx_valid;

    always #4 clk = ~clk;

    aud_serial_port uut (
        .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_frame64(cfg_frame64),
        .cfg_width(cfg_width), .bck_in(bck_in), .lr_in(lr_in), .sd_in(sd_in),
        .tx_left(tx_left), .tx_right(tx_right), .sd_out(sd_out),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 0;
    int          ncap  = 0;
    logic [23:0] cap_l [64];
    logic [23:0] cap_r [64];
    logic [23:0] il [3], ir [3], tl [3], tr [3];

    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            cap_l[ncap % 64] = rx_left;
            cap_r[ncap % 64] = rx_right;
            ncap++;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [23:0] got, input logic [23:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // position of a bit inside a half, derived from the format rules
    function automatic void exp_map(input int fmt, input int half, input int w,
                                    input bit half_left, input int p,
                                    output bit hit, output bit ch_left,
                                    output int back, output int d);
        int e, off;
        back    = 0;
        ch_left = half_left;
        if (fmt == 0) begin
            if (p == 0) begin
                e       = half - 1;
                ch_left = !half_left;
                back    = half_left ? 1 : 0;
            end else begin
                e = p - 1;
            end
        end else begin
            e = p;
        end
        off = (fmt == 2) ? half - w : 0;
        d   = e - off;
        hit = (d >= 0) && (d < w);
    endfunction

    task automatic bit_period(input logic lrv, input logic dv, output logic smp);
        @(negedge clk);
        bck_in = 1'b0;
        lr_in  = lrv;
        sd_in  = dv;
        repeat (6) @(negedge clk);
        smp    = sd_out;
        bck_in = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic run_config(input int fmt, input bit f64, input int wsel);
        int          half, w, base, n;
        logic        rlvl, llvl, s, din, dexp;
        logic [23:0] mask, word;
        bit          hit, chl;
        int          back, d, fk;
        string       ftag, ttag;

        rlvl = (fmt == 0) ? 1'b1 : 1'b0;
        llvl = ~rlvl;
        ftag = (fmt == 0) ? "R2" : (fmt == 1) ? "R1" : "R3";
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        cfg_fmt     = 2'(fmt);
        cfg_frame64 = f64;
        cfg_width   = 2'(wsel);
        bck_in = 1'b1;
        lr_in  = rlvl;
        sd_in  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(rx_valid == 1'b0, "R10", "rx_valid after reset", 24'(rx_valid), 24'h0);
        chk(rx_left == 24'h0, "R10", "rx_left after reset", rx_left, 24'h0);
        chk(rx_right == 24'h0, "R10", "rx_right after reset", rx_right, 24'h0);
        chk(sd_out == 1'b0, "R10", "sd_out after reset", 24'(sd_out), 24'h0);

        half = f64 ? 32 : 16;
        w    = !f64 ? 16 : (wsel == 0) ? 16 : (wsel == 1) ? 18 : (wsel == 2) ? 20 : 24;
        mask = ~((24'h1 << (24 - w)) - 24'h1);
        for (int k = 0; k < 3; k++) begin
            il[k] = 24'((k + 1) * 32'h3A5C91 + fmt * 32'h1F1 + wsel * 32'h0AB0C3 + (f64 ? 7 : 0));
            ir[k] = il[k] ^ 24'hA5C3E1 ^ 24'(k * 32'h111);
            tl[k] = 24'((k + 3) * 32'h6B1D27 + fmt * 32'h3C5 + wsel * 32'h50A1);
            tr[k] = tl[k] ^ 24'h9E3779;
        end
        tx_left  = tl[0];
        tx_right = tr[0];
        base     = ncap;

        for (int p = 0; p < half; p++) begin
            bit_period(rlvl, 1'b1, s);
            chk(s == 1'b0, "R10", "sd_out before first word-clock change", 24'(s), 24'h0);
        end

        for (int k = 0; k < 3; k++) begin
            for (int hl = 0; hl < 2; hl++) begin
                for (int p = 0; p < half; p++) begin
                    if (hl == 1 && p == 0 && k < 2) begin
                        tx_left  = tl[k + 1];
                        tx_right = tr[k + 1];
                    end
                    exp_map(fmt, half, w, hl == 0, p, hit, chl, back, d);
                    fk   = k - back;
                    din  = 1'b1;
                    dexp = 1'b0;
                    if (hit && fk >= 0) begin
                        word = chl ? il[fk] : ir[fk];
                        din  = word[23 - d];
                        word = chl ? tl[fk] : tr[fk];
                        dexp = word[23 - d];
                    end
                    bit_period((hl == 0) ? llvl : rlvl, din, s);
                    ttag = !hit ? "R7" : chl ? ftag : "R9";
                    chk(s == dexp, ttag, "sd_out bit", 24'(s), 24'(dexp));
                end
            end
        end
        repeat (20) @(negedge clk);

        n = ncap - base;
        chk(n >= 2, "R8", "received pair count", 24'(n), 24'h2);
        for (int i = 0; i < 2; i++) begin
            chk(cap_l[(base + i) % 64] == (il[i] & mask), ftag, "rx_left word",
                cap_l[(base + i) % 64], il[i] & mask);
            chk(cap_r[(base + i) % 64] == (ir[i] & mask), "R4", "rx_right word",
                cap_r[(base + i) % 64], ir[i] & mask);
            chk((cap_l[(base + i) % 64] & ~mask) == 24'h0, "R6", "rx_left tail bits",
                cap_l[(base + i) % 64] & ~mask, 24'h0);
            if (!f64)
                chk(cap_r[(base + i) % 64] == (ir[i] & 24'hFFFF00), "R5",
                    "short frame forces 16 bits", cap_r[(base + i) % 64], ir[i] & 24'hFFFF00);
        end
    endtask

    initial begin
        rst         = 1'b1;
        bck_in      = 1'b1;
        lr_in       = 1'b0;
        sd_in       = 1'b0;
        cfg_fmt     = 2'b00;
        cfg_frame64 = 1'b1;
        cfg_width   = 2'b00;
        tx_left     = '0;
        tx_right    = '0;
        for (int fmt = 0; fmt < 3; fmt++) begin
            for (int cs = 0; cs < 6; cs++) begin
                run_config(fmt, cs < 4, (cs < 4) ? cs : (cs == 4) ? 0 : 3);
            end
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: got unfinished run expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule